// File: doc/BRIEF.md
# I/O Channel Command Sequencer

This block is the control core of an I/O data channel. Software first starts it with a load request that carries the storage address of a command. The sequencer then reads that 36-bit command from storage and splits it into three fields: an operation code, a word count and a start address. It moves that many words between a device-side valid/ready interface and storage. Each word passes through a single data register. Successive words go to, or come from, ascending storage addresses.

When the word count of the current command reaches zero, the operation code decides what happens next. An all-zero code ends the channel's work and the block returns to idle. Any other code makes the block fetch the next command, from the address held in a command pointer. That pointer advances by one after every command fetch, so a chain of commands is laid out at consecutive locations. While the channel is working, a further load request is refused and flagged.

The storage port is a simple request/acknowledge port with a single word per access. The bus arbitration, device mechanics and unit selection sit outside the block.

Top module: `chan_cmd_exec`

## Requirements
- R1: A command word is decoded as follows. Bits [35:33] are the operation code. Bits [32:18] are the word count. Bits [14:0] are the first storage address. Bits [17:15] are ignored.
- R2: A load request seen while idle starts a command read at `load_addr`, and `busy` is high from the following cycle.
- R3: When bit 0 of the operation code is 0 (device to storage), each word accepted from the device is written to storage at ascending addresses, starting at the command's address.
- R4: When bit 0 of the operation code is 1 (storage to device), words are read from ascending storage addresses, starting at the command's address, and presented to the device in that order.
- R5: The word count drops by one and the storage address rises by one (modulo 2^15) for every word handled, so a command moves exactly its count of words.
- R6: When the count is zero and the operation code is 000, the block returns to idle and `busy` falls.
- R7: When the count is zero and the operation code is not 000, the next command is read from the command pointer. The pointer is set by the load request and increments after each command read.
- R8: A command with a zero word count moves no data.
- R9: A load request made while `busy` is high raises `busy_reject` in the next cycle and does not alter the command chain in progress.
- R10: The word written to storage equals the word accepted from the device. The word presented to the device equals the word read from storage.
- R11: Once `mem_req` is raised, it stays high with a stable address, direction and write data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Start request, one cycle |
| load_addr | input | 15 | Storage address of the first command |
| busy | output | 1 | Channel is working |
| busy_reject | output | 1 | A load request was refused in the previous cycle |
| mem_req | output | 1 | Storage access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 15 | Storage address |
| mem_wdata | output | 36 | Storage write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 36 | Storage read data |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_data | input | 36 | Word from device |
| dev_in_ready | output | 1 | Channel accepts a device word |
| dev_out_valid | output | 1 | Channel offers a word to the device |
| dev_out_data | output | 36 | Word to device |
| dev_out_ready | input | 1 | Device takes the word |

## Verification
The bench sweeps counts of one to six in both directions under three storage latencies and with stalling device handshakes. It checks the location just past each transfer, so an off-by-one counter or a count tested before the decrement would show up as an extra or a missing word. Zero-count commands are tested both as a terminator and in the middle of a chain. A design that moved a word for them, or that stopped on a non-zero code, would leave visible writes or an unfinished chain. Further cases cover an address that wraps past the top of storage, a non-zero padding field, and a load request that arrives mid-chain. A design that decoded the wrong field, or that let the refused request reload the command pointer, would corrupt the results.

// File: rtl/chan_pkg.sv
`timescale 1ns/1ps
package chan_pkg;
    localparam int WORD_W  = 36;
    localparam int OP_W    = 3;
    localparam int CNT_W   = 15;
    localparam int ADDR_W  = 15;
    localparam int OP_LSB  = WORD_W - OP_W;
    localparam int CNT_LSB = OP_LSB - CNT_W;
    localparam int DIR_BIT = 0;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OP_W-1:0]   op_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        op_t   op;
        cnt_t  cnt;
        addr_t addr;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_CHECK, ST_DEV_IN, ST_MEM_WR, ST_MEM_RD, ST_DEV_OUT
    } state_t;

    localparam op_t OP_STOP = '0;

    function automatic cmd_t split_cmd(input word_t w);
        cmd_t c;
        c.op   = w[WORD_W-1:OP_LSB];
        c.cnt  = w[OP_LSB-1:CNT_LSB];
        c.addr = w[ADDR_W-1:0];
        return c;
    endfunction

    function automatic logic ends_chain(input op_t op);
        return op == OP_STOP;
    endfunction

    function automatic logic toward_dev(input op_t op);
        return op[DIR_BIT];
    endfunction
endpackage

// File: rtl/chan_ctrl.sv
`timescale 1ns/1ps
module chan_ctrl
    import chan_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_req,
    input  logic   mem_ack,
    input  logic   dev_in_valid,
    input  logic   dev_out_ready,
    input  op_t    op,
    input  logic   cnt_zero,
    output state_t state,
    output logic   busy_reject
);
    state_t nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (load_req) nxt = ST_FETCH;
            ST_FETCH:   if (mem_ack) nxt = ST_CHECK;
            ST_CHECK: begin
                if (cnt_zero) nxt = ends_chain(op) ? ST_IDLE : ST_FETCH;
                else          nxt = toward_dev(op) ? ST_MEM_RD : ST_DEV_IN;
            end
            ST_DEV_IN:  if (dev_in_valid) nxt = ST_MEM_WR;
            ST_MEM_WR:  if (mem_ack) nxt = ST_CHECK;
            ST_MEM_RD:  if (mem_ack) nxt = ST_DEV_OUT;
            ST_DEV_OUT: if (dev_out_ready) nxt = ST_CHECK;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            busy_reject <= 1'b0;
        end else begin
            state       <= nxt;
            busy_reject <= load_req && (state != ST_IDLE);
        end
    end

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && load_req) |=> (state == ST_FETCH));
    p_refuse_r9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && load_req) |=> busy_reject);
    p_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && cnt_zero && op == OP_STOP) |=> (state == ST_IDLE));
    p_chain_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && cnt_zero && op != OP_STOP) |=> (state == ST_FETCH));
    p_nomove_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && cnt_zero) |=> !(state inside {ST_DEV_IN, ST_MEM_RD}));
endmodule

// File: rtl/chan_counters.sv
`timescale 1ns/1ps
module chan_counters
    import chan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_take,
    input  addr_t load_addr,
    input  logic  cmd_take,
    input  word_t cmd_word,
    input  logic  step,
    output op_t   op,
    output cnt_t  wc,
    output addr_t cur_addr,
    output addr_t cmd_ptr
);
    cmd_t dec;
    assign dec = split_cmd(cmd_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            op       <= OP_STOP;
            wc       <= '0;
            cur_addr <= '0;
            cmd_ptr  <= '0;
        end else begin
            if (load_take) cmd_ptr <= load_addr;
            else if (cmd_take) cmd_ptr <= cmd_ptr + 1'b1;
            if (cmd_take) begin
                op       <= dec.op;
                wc       <= dec.cnt;
                cur_addr <= dec.addr;
            end else if (step) begin
                wc       <= wc - 1'b1;
                cur_addr <= cur_addr + 1'b1;
            end
        end
    end

    p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
        (step && !cmd_take) |=> (wc == $past(wc) - 1'b1));
    p_addr_up_r5: assert property (@(posedge clk) disable iff (rst)
        (step && !cmd_take) |=> (cur_addr == $past(cur_addr) + 1'b1));
    p_ptr_up_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_take && !load_take) |=> (cmd_ptr == $past(cmd_ptr) + 1'b1));
    p_ptr_load_r2: assert property (@(posedge clk) disable iff (rst)
        load_take |=> (cmd_ptr == $past(load_addr)));
endmodule

// File: rtl/chan_data_reg.sv
`timescale 1ns/1ps
module chan_data_reg
    import chan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take_dev,
    input  word_t dev_word,
    input  logic  take_mem,
    input  word_t mem_word,
    output word_t q
);
    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (take_dev) q <= dev_word;
        else if (take_mem) q <= mem_word;
    end

    p_stage_dev_r10: assert property (@(posedge clk) disable iff (rst)
        take_dev |=> (q == $past(dev_word)));
    p_stage_mem_r10: assert property (@(posedge clk) disable iff (rst)
        (take_mem && !take_dev) |=> (q == $past(mem_word)));
endmodule

// File: rtl/chan_cmd_exec.sv
`timescale 1ns/1ps
module chan_cmd_exec
    import chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_req,
    input  logic [ADDR_W-1:0] load_addr,
    output logic              busy,
    output logic              busy_reject,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              dev_in_valid,
    input  logic [WORD_W-1:0] dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [WORD_W-1:0] dev_out_data,
    input  logic              dev_out_ready
);
    state_t state;
    op_t    op;
    cnt_t   wc;
    addr_t  cur_addr, cmd_ptr;
    word_t  dreg;
    logic   cnt_zero, load_take, cmd_take, step, take_dev, take_mem;

    assign cnt_zero  = (wc == '0);
    assign load_take = (state == ST_IDLE) && load_req;
    assign cmd_take  = (state == ST_FETCH) && mem_ack;
    assign take_dev  = (state == ST_DEV_IN) && dev_in_valid;
    assign take_mem  = (state == ST_MEM_RD) && mem_ack;
    assign step      = ((state == ST_MEM_WR) && mem_ack) ||
                       ((state == ST_DEV_OUT) && dev_out_ready);

    chan_ctrl u_ctrl (
        .clk(clk), .rst(rst), .load_req(load_req), .mem_ack(mem_ack),
        .dev_in_valid(dev_in_valid), .dev_out_ready(dev_out_ready),
        .op(op), .cnt_zero(cnt_zero), .state(state), .busy_reject(busy_reject)
    );

    chan_counters u_cnt (
        .clk(clk), .rst(rst), .load_take(load_take), .load_addr(load_addr),
        .cmd_take(cmd_take), .cmd_word(mem_rdata), .step(step),
        .op(op), .wc(wc), .cur_addr(cur_addr), .cmd_ptr(cmd_ptr)
    );

    chan_data_reg u_dreg (
        .clk(clk), .rst(rst), .take_dev(take_dev), .dev_word(dev_in_data),
        .take_mem(take_mem), .mem_word(mem_rdata), .q(dreg)
    );

    assign busy          = (state != ST_IDLE);
    assign mem_req       = state inside {ST_FETCH, ST_MEM_WR, ST_MEM_RD};
    assign mem_we        = (state == ST_MEM_WR);
    assign mem_addr      = (state == ST_FETCH) ? cmd_ptr : cur_addr;
    assign mem_wdata     = dreg;
    assign dev_in_ready  = (state == ST_DEV_IN);
    assign dev_out_valid = (state == ST_DEV_OUT);
    assign dev_out_data  = dreg;

    p_hold_req_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));
    p_out_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (dev_out_valid && !dev_out_ready) |=> (dev_out_valid && $stable(dev_out_data)));
    p_one_side_r10: assert property (@(posedge clk) disable iff (rst)
        !(dev_in_ready && dev_out_valid));
    p_busy_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && load_req) |=> (busy && mem_req && !mem_we));
endmodule

// File: tb/chan_cmd_exec_bench.sv
`timescale 1ns/1ps
module chan_cmd_exec_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_req = 1'b0;
    logic [14:0] load_addr = '0;
    logic        busy, busy_reject, mem_req, mem_we, dev_in_ready, dev_out_valid;
    logic [14:0] mem_addr;
    logic [35:0] mem_wdata, dev_out_data;
    logic        mem_ack = 1'b0;
    logic [35:0] mem_rdata = '0;
    logic        dev_in_valid = 1'b0;
    logic [35:0] dev_in_data = '0;
    logic        dev_out_ready = 1'b0;

    always #2.5 clk = ~clk;

    chan_cmd_exec u_chan_cmd_exec (
        .clk(clk), .rst(rst), .load_req(load_req), .load_addr(load_addr),
        .busy(busy), .busy_reject(busy_reject), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
        .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
    );

    int checks = 0, fails = 0;
    logic [35:0] mem [0:4095];
    int mem_lat = 0, wait_cnt = 0, wr_cnt = 0, stab_err = 0, cyc = 0;
    logic [14:0] held_addr = '0;
    int in_idx = 0, in_mode = 0;
    bit in_fire = 0;
    int out_cnt = 0, out_mode = 0;
    logic [35:0] out_log [0:255];

    function automatic logic [35:0] gen_in(int k);
        return {4'hA, k[15:0], 16'(k * 7 + 3)};
    endfunction
    function automatic logic [35:0] pre(int i);
        return {12'hC35, i[11:0], ~i[11:0]};
    endfunction
    function automatic logic [35:0] mk_cmd(logic [2:0] op, int cnt, int addr, logic [2:0] pad);
        return {op, cnt[14:0], pad, addr[14:0]};
    endfunction

    task automatic chk(bit ok, string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic preload();
        for (int i = 0; i < 4096; i++) mem[i] = pre(i);
    endtask

    // storage and device models, updated away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                chk(0, "watchdog", 36'(cyc), 36'd0);
                finish_run();
            end
            if (mem_ack) begin
                mem_ack = 1'b0;
                wait_cnt = 0;
            end else if (mem_req) begin
                if (wait_cnt == 0) held_addr = mem_addr;
                else if (mem_addr != held_addr) stab_err++;
                if (wait_cnt >= mem_lat) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        mem[mem_addr[11:0]] = mem_wdata;
                        wr_cnt++;
                    end
                    mem_rdata = mem[mem_addr[11:0]];
                end else begin
                    wait_cnt++;
                end
            end
            if (in_fire) in_idx++;
            dev_in_valid = (in_mode == 0) ? 1'b1 : (cyc % 3 != 0);
            dev_in_data  = gen_in(in_idx);
            in_fire      = dev_in_valid && dev_in_ready;
            dev_out_ready = (out_mode == 0) ? 1'b1 : (cyc % 2 == 0);
            if (dev_out_valid && dev_out_ready) begin
                out_log[out_cnt[7:0]] = dev_out_data;
                out_cnt++;
            end
        end
    end

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!busy) return;
        end
        chk(0, "R6 idle timeout", {35'd0, busy}, 36'd0);
    endtask

    task automatic start(int a);
        @(negedge clk);
        load_req = 1'b1;
        load_addr = a[14:0];
        @(negedge clk);
        load_req = 1'b0;
        chk(busy && mem_req && (mem_addr == a[14:0]), "R2 start",
            {20'd0, busy, mem_addr}, {20'd0, 1'b1, a[14:0]});
    endtask

    initial begin
        preload();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req && !dev_in_ready && !dev_out_valid && !busy_reject,
            "reset state", {31'd0, busy, mem_req, dev_in_ready, dev_out_valid, busy_reject}, 36'd0);

        // single device-to-storage command, stop code, junk in ignored field
        begin
            int base, w0;
            preload();
            mem[12'h010] = mk_cmd(3'b000, 5, 'h100, 3'b111);
            base = in_idx; w0 = wr_cnt;
            start('h010);
            wait_idle();
            chk(!busy, "R6 stop at zero", {35'd0, busy}, 36'd0);
            for (int i = 0; i < 5; i++)
                chk(mem['h100 + i] == gen_in(base + i), "R3 R10 stored word",
                    mem['h100 + i], gen_in(base + i));
            chk(mem['h105] == pre('h105), "R5 no extra word", mem['h105], pre('h105));
            chk(wr_cnt - w0 == 5, "R1 R5 count field", 36'(wr_cnt - w0), 36'd5);
        end

        // chain: out 4, in 3 with a refused load mid-way, then stop with zero count
        begin
            int base, o0;
            preload();
            mem[12'h020] = mk_cmd(3'b001, 4, 'h200, 3'b000);
            mem[12'h021] = mk_cmd(3'b010, 3, 'h300, 3'b000);
            mem[12'h022] = mk_cmd(3'b000, 0, 'h400, 3'b000);
            base = in_idx; o0 = out_cnt; out_mode = 1; in_mode = 1; mem_lat = 1;
            start('h020);
            repeat (5) @(negedge clk);
            load_req = 1'b1; load_addr = 15'h0700;
            @(negedge clk);
            load_req = 1'b0;
            chk(busy_reject, "R9 refused load flagged", {35'd0, busy_reject}, 36'd1);
            @(negedge clk);
            chk(!busy_reject, "R9 flag one cycle", {35'd0, busy_reject}, 36'd0);
            wait_idle();
            chk(out_cnt - o0 == 4, "R4 out word count", 36'(out_cnt - o0), 36'd4);
            for (int i = 0; i < 4; i++)
                chk(out_log[o0 + i] == pre('h200 + i), "R4 R10 device word",
                    out_log[o0 + i], pre('h200 + i));
            for (int i = 0; i < 3; i++)
                chk(mem['h300 + i] == gen_in(base + i), "R7 R9 chained store",
                    mem['h300 + i], gen_in(base + i));
            chk(mem['h400] == pre('h400), "R8 zero count no write", mem['h400], pre('h400));
            out_mode = 0; in_mode = 0; mem_lat = 0;
        end

        // zero count in the middle of a chain, then a read of 2
        begin
            int base, w0, o0;
            preload();
            mem[12'h030] = mk_cmd(3'b011, 0, 'h500, 3'b000);
            mem[12'h031] = mk_cmd(3'b000, 2, 'h510, 3'b000);
            base = in_idx; w0 = wr_cnt; o0 = out_cnt;
            start('h030);
            wait_idle();
            chk(out_cnt == o0, "R8 zero count no device word", 36'(out_cnt - o0), 36'd0);
            chk(wr_cnt - w0 == 2, "R7 chain after zero count", 36'(wr_cnt - w0), 36'd2);
            chk(mem['h511] == gen_in(base + 1), "R3 second word", mem['h511], gen_in(base + 1));
        end

        // lone zero-count stop command
        begin
            int w0, o0;
            preload();
            mem[12'h050] = mk_cmd(3'b000, 0, 'h050, 3'b000);
            w0 = wr_cnt; o0 = out_cnt;
            start('h050);
            wait_idle();
            chk((wr_cnt == w0) && (out_cnt == o0), "R8 nothing moved",
                36'(wr_cnt - w0 + out_cnt - o0), 36'd0);
            chk(mem['h050] == mk_cmd(3'b000, 0, 'h050, 3'b000), "R8 command intact",
                mem['h050], mk_cmd(3'b000, 0, 'h050, 3'b000));
        end

        // address wrap at the top of storage
        begin
            int base;
            preload();
            mem[12'h060] = mk_cmd(3'b000, 3, 'h7FFE, 3'b000);
            base = in_idx;
            start('h060);
            wait_idle();
            chk(mem[12'hFFE] == gen_in(base), "R5 wrap first", mem[12'hFFE], gen_in(base));
            chk(mem[12'h000] == gen_in(base + 2), "R5 wrap to zero", mem[12'h000], gen_in(base + 2));
        end

        // sweep: direction x count x storage latency
        for (int dir = 0; dir < 2; dir++)
            for (int n = 1; n <= 6; n++)
                for (int lat = 0; lat < 3; lat++) begin
                    int base, w0, o0;
                    bit ok;
                    preload();
                    mem_lat = lat; in_mode = lat % 2; out_mode = lat % 2;
                    mem[12'h040] = mk_cmd(dir ? 3'b001 : 3'b010, n, 'h800, 3'b000);
                    mem[12'h041] = mk_cmd(3'b000, 0, 0, 3'b000);
                    base = in_idx; w0 = wr_cnt; o0 = out_cnt;
                    start('h040);
                    wait_idle();
                    ok = 1;
                    if (dir == 0) begin
                        if (wr_cnt - w0 != n) ok = 0;
                        for (int i = 0; i < n; i++)
                            if (mem['h800 + i] != gen_in(base + i)) ok = 0;
                    end else begin
                        if (out_cnt - o0 != n || wr_cnt != w0) ok = 0;
                        for (int i = 0; i < n; i++)
                            if (out_log[o0 + i] != pre('h800 + i)) ok = 0;
                    end
                    if (mem['h800 + n] != pre('h800 + n)) ok = 0;
                    chk(ok, dir ? "R4 R5 sweep" : "R3 R5 sweep", 36'(n), 36'(lat));
                end

        chk(stab_err == 0, "R11 address held until ack", 36'(stab_err), 36'd0);
        finish_run();
    end
endmodule